// File: doc/BRIEF.md
# Pipelined Load/Store Unit

This unit executes integer memory operations for a 32-bit core in two stages. Dispatch hands it loads and stores through a small in-order reservation station. The operation at the head of the station has its effective address formed by an adder of its own, which adds the base register to the sign-extended 16-bit displacement. In the same cycle the unit either sends a read to the data cache or places a store into the store queue. In the second stage the unit takes the read data, selects the addressed byte, halfword or word, applies sign or zero extension, and returns the result on the writeback port.

Stores are held in a three-entry queue until the completion logic commits them. They then drain to the cache in program order, one per cycle, whenever a load is not using the cache port. A load whose bytes fall inside a queued store takes the store's data directly when the byte lanes match exactly, and waits when they only partly overlap. A mode input selects big- or little-endian byte numbering within each 32-bit word.

Top module: `lsu_top`

## Requirements
- R1: Out of reset `issue_ready_o` is 1 and no cache request or writeback is active. `issue_ready_o` is 0 whenever the reservation station holds 2 operations, and operations leave the station in the order they were accepted.
- R2: The effective address equals `issue_base_i` plus `issue_disp_i` sign-extended to 32 bits. `dc_addr_o` carries that address with bits 1:0 cleared.
- R3: A load that reaches the station head with no store-queue overlap asserts `dc_req_o` with `dc_we_o`=0 in the cycle after it is accepted. `wb_valid_o`, its tag and its data follow in the next cycle, with `dc_rdata_i` taken as the word read by the previous cycle's request.
- R4: Size codes are 0 for byte, 1 for halfword and 2 for word. `issue_signed_i`=1 sign-extends byte and halfword results and 0 zero-extends them.
- R5: When `big_endian_i`=0, the byte at word offset k sits in bits 8k+7:8k and a halfword takes its low byte from the lower address. When `big_endian_i`=1, offset k sits in lane 3-k and the lower address holds the more significant byte. Stores use the same lane mapping, and `dc_be_o` bit n enables lane n.
- R6: A store never writes the cache before it is committed. Each cycle with `commit_i`=1 commits the oldest queued store that is not yet committed. A commit pulse with no uncommitted queued store has no effect and is not saved for later stores.
- R7: Committed stores write the cache in the order they were issued, one per cycle on consecutive cycles when no load read competes.
- R8: The store queue holds 3 stores. A store at the station head waits while the queue is full, so later operations fill the station and `issue_ready_o` falls.
- R9: A load whose byte enables equal those of the youngest queued store to the same word receives that store's data with no cache read.
- R10: A load that overlaps the youngest matching queued store on only some byte lanes waits until that store has drained, then reads the merged word from the cache.
- R11: Address bits below the access size are ignored: halfwords use bit 0 as zero and words use bits 1:0 as zero.
- R12: When a load read and a committed store drain both want the cache in one cycle, the load read goes first and the drain follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| big_endian_i | input | 1 | 1 selects big-endian byte numbering |
| issue_valid_i | input | 1 | Dispatch offers an operation |
| issue_ready_o | output | 1 | Reservation station has room |
| issue_store_i | input | 1 | 1 for a store, 0 for a load |
| issue_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| issue_signed_i | input | 1 | Sign-extend load result |
| issue_base_i | input | 32 | Base register value |
| issue_disp_i | input | 16 | Signed displacement |
| issue_sdata_i | input | 32 | Store data, right-aligned |
| issue_tag_i | input | TAG_W | Result tag for loads |
| commit_i | input | 1 | Commit the oldest uncommitted store |
| dc_req_o | output | 1 | Cache access this cycle |
| dc_we_o | output | 1 | Access is a write |
| dc_addr_o | output | 32 | Word-aligned address |
| dc_be_o | output | 4 | Byte lane enables |
| dc_wdata_o | output | 32 | Lane-placed write data |
| dc_rdata_i | input | 32 | Read data, one cycle after request |
| wb_valid_o | output | 1 | Load result valid |
| wb_tag_o | output | TAG_W | Tag of the load result |
| wb_data_o | output | 32 | Formatted load result |

## Verification
The bench builds the unit with its default parameters: a 2-entry reservation station, a 3-entry store queue and 4-bit tags. With these depths, three uncommitted stores fill the queue, and two more operations then fill the station and hold off dispatch. This makes the full-queue and full-station limits reachable in a handful of cycles. The same small queue lets the bench drive forwarding, partial-overlap stalls and the read-versus-drain conflict on the cache port from short, exactly timed sequences.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN = 32;
  localparam int DISP_W = 16;
  localparam int BE_W = XLEN / 8;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef struct packed {
    logic [XLEN-3:0] waddr;
    logic [BE_W-1:0] be;
    logic [XLEN-1:0] data;
  } sq_entry_t;
endpackage

// File: rtl/lsu_rs.sv
module lsu_rs #(
  parameter int DEPTH = 2,
  parameter int W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  output logic          ready_o,
  input  logic          pop_i,
  output logic          valid_o,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  slot [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] wr_idx;

  assign wr_idx  = cnt - CW'(pop_i);
  assign ready_o = cnt < CW'(DEPTH);
  assign valid_o = cnt != '0;
  assign head_o  = slot[0];
  assign cnt_o   = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt + CW'(push_i) - CW'(pop_i);
  end

  // shift toward slot 0 on pop, new entry lands behind the survivors
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && wr_idx == CW'(i))    slot[i] <= data_i;
      else if (pop_i && i < DEPTH - 1)   slot[i] <= slot[i + ((i < DEPTH - 1) ? 1 : 0)];
    end
  end
endmodule

// File: rtl/lsu_sq.sv
module lsu_sq
  import lsu_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  sq_entry_t       entry_i,
  input  logic            commit_i,
  input  logic            pop_i,
  output sq_entry_t       head_o,
  output logic            head_commit_o,
  output logic            full_o,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   ccnt_o,
  input  logic [XLEN-3:0] ld_waddr_i,
  input  logic [BE_W-1:0] ld_be_i,
  output logic            fwd_hit_o,
  output logic            fwd_exact_o,
  output logic [XLEN-1:0] fwd_data_o
);
  sq_entry_t     q [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] ccnt;
  logic [CW-1:0] wr_idx;
  logic [DEPTH-1:0] hit;

  assign wr_idx        = cnt - CW'(pop_i);
  assign full_o        = cnt == CW'(DEPTH);
  assign head_o        = q[0];
  assign head_commit_o = ccnt != '0;
  assign cnt_o         = cnt;
  assign ccnt_o        = ccnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt  <= '0;
      ccnt <= '0;
    end else begin
      cnt  <= cnt + CW'(push_i) - CW'(pop_i);
      ccnt <= ccnt - CW'(pop_i) + CW'(commit_i && (ccnt < cnt));
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && wr_idx == CW'(i))  q[i] <= entry_i;
      else if (pop_i && i < DEPTH - 1) q[i] <= q[i + ((i < DEPTH - 1) ? 1 : 0)];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign hit[g] = (CW'(g) < cnt) && (q[g].waddr == ld_waddr_i) && |(q[g].be & ld_be_i);
  end

  // higher index is younger: last hit wins
  always_comb begin
    fwd_hit_o   = 1'b0;
    fwd_exact_o = 1'b0;
    fwd_data_o  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit[i]) begin
        fwd_hit_o   = 1'b1;
        fwd_exact_o = q[i].be == ld_be_i;
        fwd_data_o  = q[i].data;
      end
    end
  end
endmodule

// File: rtl/lsu_fmt.sv
module lsu_fmt
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  input  logic [1:0]      loff_i,
  input  logic [1:0]      size_i,
  input  logic            sgn_i,
  output logic [XLEN-1:0] data_o
);
  logic [7:0]  b;
  logic [15:0] h;

  assign b = word_i[{loff_i, 3'b000} +: 8];
  assign h = word_i[{loff_i[1], 4'b0000} +: 16];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(XLEN-8){sgn_i & b[7]}}, b};
      SZ_HALF: data_o = {{(XLEN-16){sgn_i & h[15]}}, h};
      default: data_o = word_i;
    endcase
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int RS_DEPTH = 2,
  parameter int SQ_DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             big_endian_i,
  input  logic             issue_valid_i,
  output logic             issue_ready_o,
  input  logic             issue_store_i,
  input  logic [1:0]       issue_size_i,
  input  logic             issue_signed_i,
  input  logic [31:0]      issue_base_i,
  input  logic [15:0]      issue_disp_i,
  input  logic [31:0]      issue_sdata_i,
  input  logic [TAG_W-1:0] issue_tag_i,
  input  logic             commit_i,
  output logic             dc_req_o,
  output logic             dc_we_o,
  output logic [31:0]      dc_addr_o,
  output logic [3:0]       dc_be_o,
  output logic [31:0]      dc_wdata_o,
  input  logic [31:0]      dc_rdata_i,
  output logic             wb_valid_o,
  output logic [TAG_W-1:0] wb_tag_o,
  output logic [31:0]      wb_data_o
);
  localparam int OP_W = 1 + 2 + 1 + XLEN + DISP_W + XLEN + TAG_W;
  localparam int RCW  = $clog2(RS_DEPTH + 1);
  localparam int SCW  = $clog2(SQ_DEPTH + 1);

  // reservation station
  logic            rs_push, rs_pop, hd_v;
  logic [OP_W-1:0] rs_head;
  logic [RCW-1:0]  rs_cnt;

  logic              hd_st, hd_sgn;
  logic [1:0]        hd_size;
  logic [XLEN-1:0]   hd_base, hd_sdata;
  logic [DISP_W-1:0] hd_disp;
  logic [TAG_W-1:0]  hd_tag;

  assign rs_push = issue_valid_i && issue_ready_o;

  lsu_rs #(.DEPTH(RS_DEPTH), .W(OP_W)) u_rs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rs_push),
    .data_i  ({issue_store_i, issue_size_i, issue_signed_i, issue_base_i,
               issue_disp_i, issue_sdata_i, issue_tag_i}),
    .ready_o (issue_ready_o),
    .pop_i   (rs_pop),
    .valid_o (hd_v),
    .head_o  (rs_head),
    .cnt_o   (rs_cnt)
  );

  assign {hd_st, hd_size, hd_sgn, hd_base, hd_disp, hd_sdata, hd_tag} = rs_head;

  // stage 1: address, lanes, cache / queue access
  logic [XLEN-1:0] ea, wd;
  logic [1:0]      off, xm, loff;
  logic [3:0]      msk, be;

  assign ea = hd_base + {{(XLEN-DISP_W){hd_disp[DISP_W-1]}}, hd_disp};

  always_comb begin
    case (hd_size)
      SZ_BYTE: begin off = ea[1:0];      xm = 2'b11; msk = 4'b0001; wd = {4{hd_sdata[7:0]}};  end
      SZ_HALF: begin off = {ea[1], 1'b0}; xm = 2'b10; msk = 4'b0011; wd = {2{hd_sdata[15:0]}}; end
      default: begin off = 2'b00;        xm = 2'b00; msk = 4'b1111; wd = hd_sdata;            end
    endcase
    loff = big_endian_i ? (off ^ xm) : off;
    be   = msk << loff;
  end

  sq_entry_t       sq_head;
  logic            sq_push, sq_pop, sq_head_commit, sq_full;
  logic [SCW-1:0]  sq_cnt, sq_ccnt;
  logic            fwd_hit, fwd_exact;
  logic [XLEN-1:0] fwd_data;
  logic            is_ld, ld_fire, ld_rd, drain;

  assign is_ld   = hd_v && !hd_st;
  assign ld_fire = is_ld && !(fwd_hit && !fwd_exact);
  assign ld_rd   = ld_fire && !fwd_hit;
  assign sq_push = hd_v && hd_st && !sq_full;
  assign rs_pop  = ld_fire || sq_push;
  assign drain   = sq_head_commit && !ld_rd;
  assign sq_pop  = drain;

  lsu_sq #(.DEPTH(SQ_DEPTH)) u_sq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .push_i        (sq_push),
    .entry_i       ('{waddr: ea[XLEN-1:2], be: be, data: wd}),
    .commit_i      (commit_i),
    .pop_i         (sq_pop),
    .head_o        (sq_head),
    .head_commit_o (sq_head_commit),
    .full_o        (sq_full),
    .cnt_o         (sq_cnt),
    .ccnt_o        (sq_ccnt),
    .ld_waddr_i    (ea[XLEN-1:2]),
    .ld_be_i       (be),
    .fwd_hit_o     (fwd_hit),
    .fwd_exact_o   (fwd_exact),
    .fwd_data_o    (fwd_data)
  );

  assign dc_req_o   = ld_rd || drain;
  assign dc_we_o    = drain;
  assign dc_addr_o  = ld_rd ? {ea[XLEN-1:2], 2'b00} : {sq_head.waddr, 2'b00};
  assign dc_be_o    = ld_rd ? be : sq_head.be;
  assign dc_wdata_o = drain ? sq_head.data : '0;

  // stage 2: format and write back
  logic             s2_v, s2_sgn, s2_fwd;
  logic [1:0]       s2_size, s2_loff;
  logic [TAG_W-1:0] s2_tag;
  logic [XLEN-1:0]  s2_fdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s2_v <= 1'b0;
    else         s2_v <= ld_fire;
  end

  always_ff @(posedge clk_i) begin
    if (ld_fire) begin
      s2_tag   <= hd_tag;
      s2_size  <= hd_size;
      s2_sgn   <= hd_sgn;
      s2_loff  <= loff;
      s2_fwd   <= fwd_hit;
      s2_fdata <= fwd_data;
    end
  end

  lsu_fmt u_fmt (
    .word_i (s2_fwd ? s2_fdata : dc_rdata_i),
    .loff_i (s2_loff),
    .size_i (s2_size),
    .sgn_i  (s2_sgn),
    .data_o (wb_data_o)
  );

  assign wb_valid_o = s2_v;
  assign wb_tag_o   = s2_tag;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker #(
  parameter int RS_DEPTH = 2,
  parameter int SQ_DEPTH = 3,
  localparam int RCW = $clog2(RS_DEPTH + 1),
  localparam int SCW = $clog2(SQ_DEPTH + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           issue_ready_o,
  input logic [RCW-1:0] rs_cnt,
  input logic           dc_req_o,
  input logic           dc_we_o,
  input logic [3:0]     dc_be_o,
  input logic           wb_valid_o,
  input logic           sq_push,
  input logic [SCW-1:0] sq_cnt,
  input logic [SCW-1:0] sq_ccnt
);
  AST_RS_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_cnt == RCW'(RS_DEPTH) |-> !issue_ready_o);  // R1
  AST_LOAD_WB_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_req_o && !dc_we_o |=> wb_valid_o);  // R3
  AST_WRITE_COMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_req_o && dc_we_o |-> sq_ccnt != '0);  // R6
  AST_COMMIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_ccnt <= sq_cnt);  // R6
  AST_WRITE_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_req_o && dc_we_o |-> dc_be_o != 4'b0000);  // R7
  AST_SQ_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_cnt <= SCW'(SQ_DEPTH));  // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_push |-> sq_cnt < SCW'(SQ_DEPTH));  // R8
endmodule

bind lsu_top lsu_checker #(.RS_DEPTH(RS_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_ready_o (issue_ready_o),
  .rs_cnt        (rs_cnt),
  .dc_req_o      (dc_req_o),
  .dc_we_o       (dc_we_o),
  .dc_be_o       (dc_be_o),
  .wb_valid_o    (wb_valid_o),
  .sq_push       (sq_push),
  .sq_cnt        (sq_cnt),
  .sq_ccnt       (sq_ccnt)
);

// File: tb/sim_lsu_top.sv
`timescale 1ns/1ps
module sim_lsu_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        issue_valid_i = 1'b0;
  logic        issue_ready_o;
  logic        issue_store_i = 1'b0;
  logic [1:0]  issue_size_i = 2'd0;
  logic        issue_signed_i = 1'b0;
  logic [31:0] issue_base_i = '0;
  logic [15:0] issue_disp_i = '0;
  logic [31:0] issue_sdata_i = '0;
  logic [3:0]  issue_tag_i = '0;
  logic        commit_i = 1'b0;
  logic        dc_req_o, dc_we_o;
  logic [31:0] dc_addr_o, dc_wdata_o;
  logic [3:0]  dc_be_o;
  logic [31:0] dc_rdata_i = '0;
  logic        wb_valid_o;
  logic [3:0]  wb_tag_o;
  logic [31:0] wb_data_o;

  always #2 clk = ~clk;

  lsu_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .big_endian_i(big_endian_i),
    .issue_valid_i(issue_valid_i), .issue_ready_o(issue_ready_o),
    .issue_store_i(issue_store_i), .issue_size_i(issue_size_i),
    .issue_signed_i(issue_signed_i), .issue_base_i(issue_base_i),
    .issue_disp_i(issue_disp_i), .issue_sdata_i(issue_sdata_i),
    .issue_tag_i(issue_tag_i), .commit_i(commit_i),
    .dc_req_o(dc_req_o), .dc_we_o(dc_we_o), .dc_addr_o(dc_addr_o),
    .dc_be_o(dc_be_o), .dc_wdata_o(dc_wdata_o), .dc_rdata_i(dc_rdata_i),
    .wb_valid_o(wb_valid_o), .wb_tag_o(wb_tag_o), .wb_data_o(wb_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // cache model: one-cycle read latency, writes visible next cycle
  logic [31:0] mem [64];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dc_req_o) begin
      if (dc_we_o) begin
        for (int l = 0; l < 4; l++)
          if (dc_be_o[l]) mem[dc_addr_o[7:2]][l*8 +: 8] <= dc_wdata_o[l*8 +: 8];
      end else begin
        dc_rdata_i <= mem[dc_addr_o[7:2]];
      end
    end
  end

  // observers
  logic [31:0] got [16];
  logic        seen [16];
  logic [31:0] w_addr [64];
  logic [31:0] w_data [64];
  logic [3:0]  w_be [64];
  int          w_cyc [64];
  int nw = 0;
  int nr = 0;

  always @(negedge clk) begin
    if (wb_valid_o) begin
      got[wb_tag_o]  = wb_data_o;
      seen[wb_tag_o] = 1'b1;
    end
    if (dc_req_o && dc_we_o && nw < 64) begin
      w_addr[nw] = dc_addr_o; w_data[nw] = dc_wdata_o;
      w_be[nw] = dc_be_o; w_cyc[nw] = cyc; nw++;
    end
    if (dc_req_o && !dc_we_o) nr++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_issue(logic st, logic [1:0] sz, logic sg, logic [31:0] base,
                          logic [15:0] disp, logic [31:0] sd, logic [3:0] tg);
    @(negedge clk);
    issue_valid_i = 1'b1; issue_store_i = st; issue_size_i = sz; issue_signed_i = sg;
    issue_base_i = base; issue_disp_i = disp; issue_sdata_i = sd; issue_tag_i = tg;
    while (!issue_ready_o) @(negedge clk);
    @(negedge clk);
    issue_valid_i = 1'b0;
  endtask

  task automatic pulse_commit();
    @(negedge clk); commit_i = 1'b1;
    @(negedge clk); commit_i = 1'b0;
  endtask

  task automatic ld_check(string rq, logic [1:0] sz, logic sg, logic [31:0] base,
                          logic [15:0] disp, logic [3:0] tg, logic [31:0] exp);
    seen[tg] = 1'b0;
    do_issue(1'b0, sz, sg, base, disp, 32'h0, tg);
    for (int k = 0; k < 10 && !seen[tg]; k++) @(posedge clk);
    #1;
    chk({rq, " result seen"}, {31'b0, seen[tg]}, 32'd1);
    chk(rq, got[tg], exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset ready", {31'b0, issue_ready_o}, 32'd1);
    chk("R1 reset wb idle", {31'b0, wb_valid_o}, 32'd0);
    chk("R1 reset no request", {31'b0, dc_req_o}, 32'd0);
  endtask

  task automatic t_addr_latency();
    do_issue(1'b0, 2'd2, 1'b0, 32'h40, 16'hFFFC, 32'h0, 4'd1);
    chk("R3 read request next cycle", {30'b0, dc_req_o, dc_we_o}, 32'd2);
    chk("R2 negative displacement", dc_addr_o, 32'h3C);
    @(negedge clk);
    chk("R3 writeback valid", {31'b0, wb_valid_o}, 32'd1);
    chk("R3 writeback tag", {28'b0, wb_tag_o}, 32'd1);
    chk("R3 writeback data", wb_data_o, mem[15]);
    ld_check("R2 positive displacement", 2'd2, 1'b0, 32'h10, 16'h0024, 4'd2, mem[13]);
  endtask

  task automatic t_format_le();
    big_endian_i = 1'b0;
    ld_check("R4 byte signed neg", 2'd0, 1'b1, 32'h12, 16'h0, 4'd3, 32'hFFFF_FFFF);
    ld_check("R4 byte unsigned", 2'd0, 1'b0, 32'h12, 16'h0, 4'd4, 32'h0000_00FF);
    ld_check("R4 byte signed pos", 2'd0, 1'b1, 32'h11, 16'h0, 4'd5, 32'h0000_007F);
    ld_check("R4 half signed", 2'd1, 1'b1, 32'h12, 16'h0, 4'd6, 32'hFFFF_80FF);
    ld_check("R4 half unsigned", 2'd1, 1'b0, 32'h10, 16'h0, 4'd7, 32'h0000_7F01);
    ld_check("R4 word", 2'd2, 1'b1, 32'h10, 16'h0, 4'd8, 32'h80FF_7F01);
  endtask

  task automatic t_format_be();
    big_endian_i = 1'b1;
    ld_check("R5 byte offset 0", 2'd0, 1'b1, 32'h10, 16'h0, 4'd3, 32'hFFFF_FF80);
    ld_check("R5 byte offset 3", 2'd0, 1'b0, 32'h13, 16'h0, 4'd4, 32'h0000_0001);
    ld_check("R5 half offset 0", 2'd1, 1'b0, 32'h10, 16'h0, 4'd5, 32'h0000_80FF);
    ld_check("R5 half offset 2", 2'd1, 1'b1, 32'h12, 16'h0, 4'd6, 32'h0000_7F01);
    ld_check("R5 word", 2'd2, 1'b0, 32'h10, 16'h0, 4'd7, 32'h80FF_7F01);
    big_endian_i = 1'b0;
  endtask

  task automatic t_align();
    ld_check("R11 half odd address", 2'd1, 1'b0, 32'h13, 16'h0, 4'd9, 32'h0000_80FF);
    ld_check("R11 word unaligned", 2'd2, 1'b0, 32'h11, 16'h0, 4'd10, 32'h80FF_7F01);
  endtask

  task automatic t_commit();
    int n0 = nw;
    do_issue(1'b1, 2'd2, 1'b0, 32'h20, 16'h0, 32'hDEAD_BEEF, 4'd0);
    idle(6);
    chk("R6 no write before commit", nw, n0);
    pulse_commit();
    idle(3);
    chk("R6 write after commit", nw, n0 + 1);
    chk("R6 write address", w_addr[n0], 32'h20);
    chk("R6 write data", w_data[n0], 32'hDEAD_BEEF);
    chk("R6 write lanes", {28'b0, w_be[n0]}, 32'hF);
    pulse_commit();  // nothing to commit: must not be banked
    idle(2);
    n0 = nw;
    do_issue(1'b1, 2'd2, 1'b0, 32'h24, 16'h0, 32'h1234_5678, 4'd0);
    idle(6);
    chk("R6 stray commit ignored", nw, n0);
    pulse_commit();
    idle(3);
    chk("R6 later commit drains", nw, n0 + 1);
  endtask

  task automatic t_fifo();
    int n0 = nw;
    do_issue(1'b1, 2'd2, 1'b0, 32'h40, 16'h0, 32'hA1A1_A1A1, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h44, 16'h0, 32'hB2B2_B2B2, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h48, 16'h0, 32'hC3C3_C3C3, 4'd0);
    idle(2);
    @(negedge clk); commit_i = 1'b1;
    repeat (3) @(negedge clk);
    commit_i = 1'b0;
    idle(6);
    chk("R7 three writes", nw, n0 + 3);
    chk("R7 first address", w_addr[n0], 32'h40);
    chk("R7 second address", w_addr[n0+1], 32'h44);
    chk("R7 third address", w_addr[n0+2], 32'h48);
    chk("R7 back-to-back 1", w_cyc[n0+1] - w_cyc[n0], 1);
    chk("R7 back-to-back 2", w_cyc[n0+2] - w_cyc[n0+1], 1);
    ld_check("R7 drained data readable", 2'd2, 1'b0, 32'h44, 16'h0, 4'd11, 32'hB2B2_B2B2);
  endtask

  task automatic t_full();
    int n0 = nw;
    do_issue(1'b1, 2'd2, 1'b0, 32'h50, 16'h0, 32'h5050_5050, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h54, 16'h0, 32'h5454_5454, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h58, 16'h0, 32'h5858_5858, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h5C, 16'h0, 32'h5C5C_5C5C, 4'd0);
    do_issue(1'b1, 2'd2, 1'b0, 32'h60, 16'h0, 32'h6060_6060, 4'd0);
    chk("R8 station full blocks issue", {31'b0, issue_ready_o}, 32'd0);
    idle(4);
    chk("R8 ready stays low", {31'b0, issue_ready_o}, 32'd0);
    for (int k = 0; k < 5; k++) begin
      pulse_commit();
      idle(3);
    end
    chk("R8 all five written", nw, n0 + 5);
    chk("R8 last address in order", w_addr[n0+4], 32'h60);
    chk("R8 ready again", {31'b0, issue_ready_o}, 32'd1);
  endtask

  task automatic t_forward();
    int r0;
    do_issue(1'b1, 2'd2, 1'b0, 32'h70, 16'h0, 32'hCAFE_F00D, 4'd0);
    r0 = nr;
    ld_check("R9 word forward", 2'd2, 1'b0, 32'h70, 16'h0, 4'd12, 32'hCAFE_F00D);
    chk("R9 no cache read", nr, r0);
    do_issue(1'b1, 2'd0, 1'b0, 32'h74, 16'h0, 32'h0000_00E5, 4'd0);
    r0 = nr;
    ld_check("R9 byte forward signed", 2'd0, 1'b1, 32'h74, 16'h0, 4'd13, 32'hFFFF_FFE5);
    chk("R9 byte no cache read", nr, r0);
    pulse_commit(); idle(2);
    pulse_commit(); idle(3);
  endtask

  task automatic t_stall();
    logic [31:0] old = mem[30];
    do_issue(1'b1, 2'd0, 1'b0, 32'h79, 16'h0, 32'h0000_003C, 4'd0);
    seen[14] = 1'b0;
    do_issue(1'b0, 2'd2, 1'b0, 32'h78, 16'h0, 32'h0, 4'd14);
    idle(6);
    chk("R10 partial overlap waits", {31'b0, seen[14]}, 32'd0);
    pulse_commit();
    for (int k = 0; k < 10 && !seen[14]; k++) @(posedge clk);
    #1;
    chk("R10 load completes after drain", {31'b0, seen[14]}, 32'd1);
    chk("R10 merged data", got[14], (old & 32'hFFFF_00FF) | 32'h0000_3C00);
  endtask

  task automatic t_priority();
    do_issue(1'b1, 2'd2, 1'b0, 32'h80, 16'h0, 32'h8080_8080, 4'd0);
    idle(2);
    @(negedge clk);
    issue_valid_i = 1'b1; issue_store_i = 1'b0; issue_size_i = 2'd2; issue_signed_i = 1'b0;
    issue_base_i = 32'h10; issue_disp_i = 16'h0; issue_tag_i = 4'd15;
    commit_i = 1'b1;
    @(negedge clk);
    issue_valid_i = 1'b0; commit_i = 1'b0;
    chk("R12 read wins port", {30'b0, dc_req_o, dc_we_o}, 32'd2);
    @(negedge clk);
    chk("R12 drain follows", {30'b0, dc_req_o, dc_we_o}, 32'd3);
    chk("R12 drain address", dc_addr_o, 32'h80);
    idle(2);
  endtask

  task automatic t_store_be();
    int n0 = nw;
    big_endian_i = 1'b1;
    do_issue(1'b1, 2'd0, 1'b0, 32'h91, 16'h0, 32'h0000_005A, 4'd0);
    pulse_commit();
    idle(3);
    chk("R5 big-endian store lanes", {28'b0, w_be[n0]}, 32'h4);
    chk("R5 big-endian store byte", {24'b0, w_data[n0][23:16]}, 32'h5A);
    ld_check("R5 big-endian byte reload", 2'd0, 1'b0, 32'h91, 16'h0, 4'd2, 32'h0000_005A);
    big_endian_i = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h3C00_0000 | (i << 8) | i;
    mem[4] = 32'h80FF_7F01;
    for (int i = 0; i < 16; i++) begin seen[i] = 1'b0; got[i] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_addr_latency();
    t_format_le();
    t_format_be();
    t_align();
    t_commit();
    t_fifo();
    t_full();
    t_forward();
    t_stall();
    t_priority();
    t_store_be();
    summary();
    $finish;
  end
endmodule